// File: doc/BRIEF.md
# Task-File Configuration Unlock Snooper

This block sits on the slave side of a legacy ATA task-file decode. It observes every host access to the eight command-block ports and to the alternate-status port. A specific seven-access pattern, mixing reads of several ports with one write, switches the channel into a configuration state. In that state two otherwise hidden registers become reachable at command-block offsets 3 and 4. The host confirms that it has entered the configuration state by reading back the sector-count register. The block clears bit 7 of that register when the pattern completes, even though the host had just set that bit.

Offset 3 holds a 3-bit strobe-timing code for each drive. Timing changes are first written to a staging copy. A commit write moves them to the outputs that feed the PIO strobe generator, and a later key read closes the configuration state again. Separately, the block watches for a run of consecutive sector-count reads and raises a flag that selects 32-bit width for the data port.

Top module: `tfu_unlock_snoop`

## Requirements
- R1: After synchronous reset the port is locked, all timing fields, decoded modes and the auxiliary field are 0, the wide flag is low, and the sector-count register reads 0x00.
- R2: The address is {ctl, ofs[2:0]}: ctl=0 selects command-block offset ofs, and 0xE is the alternate-status port. While locked, these seven accesses in order open the port on the edge of the last one: read 0x5 (key), write 0x2 with bit 7 set, read 0x2, read 0xE, read 0xE, read 0x2, read 0x2. Idle cycles between the accesses do not matter.
- R3: A write to 0x2 stores all 8 bits in any state. When the pattern completes, bit 7 of the stored value is cleared. If the pattern is not completed, the value reads back exactly as written.
- R4: Any access that does not match the next expected step sends the matcher back to idle, except a key read, which restarts the match at step two. This lets the host retry the whole pattern.
- R5: While open, offset 0x3 reads and writes a staging register in which drive n occupies bits [3n+2:3n]. Each new opening reloads the staging register from the active timing. While locked, offsets 0x3 and 0x4 are neither claimed nor stored.
- R6: While open, a write to 0x2 with bit 0 set copies the staging register to `drv_timing` on that edge. `drv_timing` changes at no other time.
- R7: A key read after a commit relocks the port. A key read while open without a prior commit leaves the port open.
- R8: While open, a write to 0x4 keeps only bits [2:0]. These drive `aux_ctrl` and read back zero-extended.
- R9: Each drive's mode decodes from its active field: 0 gives mode 0, 4 gives mode 1, 7 gives mode 2, and every other code gives mode 0.
- R10: Three consecutive reads of 0x2 raise `wide_mode`. Data-port (0x0) accesses keep the flag but break the run. Any other access clears both the flag and the run.
- R11: A read is claimed only for 0x2, or for 0x3 and 0x4 while open. Unclaimed reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | {ctl, ofs}; 0xE is alternate status |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access; wins over io_rd |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the strobe cycle |
| io_rd_claim | output | 1 | Block drives io_rdata for this read |
| cfg_open | output | 1 | Configuration state active |
| drv_timing | output | 6 | Active timing fields, drive n at [3n+2:3n] |
| drv_pio_mode | output | 4 | Decoded mode per drive, 2 bits each |
| aux_ctrl | output | 3 | Auxiliary control field |
| wide_mode | output | 1 | 32-bit data-port width armed |

## Verification
If the matcher's step register is wrong, the fault shows up at the edge of the final pattern access: either `cfg_open` rises too early or it never rises. The next sector-count read then shows bit 7 in the wrong state. A corrupt staging register stays hidden at the outputs until the next commit or the next read of offset 3, so the bench reads offset 3 back before every commit. A wrong count of consecutive sector-count reads shows on `wide_mode` one edge after the third read.

// File: rtl/tfu_pkg.sv
package tfu_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int FIELD_W  = 3;
    localparam int AUX_W    = 3;
    localparam int MAX_MODE = 2;

    localparam logic [2:0] OFS_DATA   = 3'd0;
    localparam logic [2:0] OFS_SECCNT = 3'd2;
    localparam logic [2:0] OFS_TIMING = 3'd3;
    localparam logic [2:0] OFS_AUX    = 3'd4;
    localparam logic [2:0] OFS_KEY    = 3'd5;
    localparam logic [2:0] OFS_ALT    = 3'd6;

    typedef enum logic [2:0] {
        AC_NONE, AC_RD_SC, AC_WR_SC, AC_RD_KEY, AC_RD_ALT, AC_DATA, AC_OTHER
    } acc_kind_e;

    typedef enum logic [2:0] {
        M_IDLE, M_GOT_KEY, M_GOT_WR, M_RD1, M_ALT1, M_ALT2, M_RD2
    } match_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic               rd;
        logic               wr;
        logic               ctl;
        logic [2:0]         ofs;
        logic [DATA_W-1:0]  wdata;
    } bus_acc_t;

    function automatic acc_kind_e classify(logic rd, logic wr, logic ctl, logic [2:0] ofs);
        acc_kind_e k;
        if (!rd && !wr)               k = AC_NONE;
        else if (ctl)                 k = (!wr && ofs == OFS_ALT) ? AC_RD_ALT : AC_OTHER;
        else if (ofs == OFS_DATA)     k = AC_DATA;
        else if (ofs == OFS_SECCNT)   k = wr ? AC_WR_SC : AC_RD_SC;
        else if (ofs == OFS_KEY && !wr) k = AC_RD_KEY;
        else                          k = AC_OTHER;
        return k;
    endfunction

    // Access kind that advances the matcher from a given step
    function automatic acc_kind_e step_wants(match_e s);
        acc_kind_e k;
        case (s)
            M_IDLE:    k = AC_RD_KEY;
            M_GOT_KEY: k = AC_WR_SC;
            M_GOT_WR:  k = AC_RD_SC;
            M_RD1:     k = AC_RD_ALT;
            M_ALT1:    k = AC_RD_ALT;
            M_ALT2:    k = AC_RD_SC;
            default:   k = AC_RD_SC;
        endcase
        return k;
    endfunction

    function automatic logic [1:0] field_to_mode(logic [FIELD_W-1:0] f);
        logic [1:0] m;
        m = 2'd0;
        for (int k = 1; k <= MAX_MODE; k++)
            if (f == FIELD_W'(1 + 3 * k)) m = 2'(k);
        return m;
    endfunction

endpackage

// File: rtl/tfu_seq_match.sv
module tfu_seq_match
    import tfu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  acc_kind_e kind,
    input  logic      wbit7,
    output logic      done
);
    match_e step, step_n;
    logic   acc_ok;

    always_comb begin
        step_n = step;
        done   = 1'b0;
        acc_ok = (kind == step_wants(step)) && (step != M_GOT_KEY || wbit7);
        if (!enable) begin
            step_n = M_IDLE;
        end else if (kind != AC_NONE) begin
            if (acc_ok) begin
                if (step == M_RD2) begin
                    step_n = M_IDLE;
                    done   = 1'b1;
                end else begin
                    step_n = match_e'(step + 3'd1);
                end
            end else begin
                step_n = (kind == AC_RD_KEY) ? M_GOT_KEY : M_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step <= M_IDLE;
        else     step <= step_n;
    end
endmodule

// File: rtl/tfu_lock_ctrl.sv
module tfu_lock_ctrl
    import tfu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      done,
    input  acc_kind_e kind,
    input  logic      wbit0,
    output logic      open,
    output logic      commit
);
    logic pending;

    assign commit = open && kind == AC_WR_SC && wbit0;

    always_ff @(posedge clk) begin
        if (rst) begin
            open    <= 1'b0;
            pending <= 1'b0;
        end else if (done) begin
            open    <= 1'b1;
            pending <= 1'b0;
        end else if (open) begin
            if (commit) begin
                pending <= 1'b1;
            end else if (kind == AC_RD_KEY && pending) begin
                open    <= 1'b0;
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tfu_timing_bank.sv
module tfu_timing_bank
    import tfu_pkg::*;
#(
    parameter int NUM_DRV = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  bus_acc_t                      acc,
    input  logic                          open,
    input  logic                          done,
    input  logic                          commit,
    output logic [DATA_W-1:0]             rdata,
    output logic                          claim,
    output logic [NUM_DRV*FIELD_W-1:0]    timing,
    output logic [NUM_DRV*2-1:0]          pio_mode,
    output logic [AUX_W-1:0]              aux
);
    localparam int TW = NUM_DRV * FIELD_W;

    logic [DATA_W-1:0] seccnt;
    logic [TW-1:0]     stage;
    logic              tim_wr, aux_wr, tim_rd, aux_rd, sc_rd;

    assign tim_wr = open && acc.wr && !acc.ctl && acc.ofs == OFS_TIMING;
    assign aux_wr = open && acc.wr && !acc.ctl && acc.ofs == OFS_AUX;
    assign tim_rd = open && acc.rd && !acc.ctl && acc.ofs == OFS_TIMING;
    assign aux_rd = open && acc.rd && !acc.ctl && acc.ofs == OFS_AUX;
    assign sc_rd  = acc.kind == AC_RD_SC;

    always_ff @(posedge clk) begin
        if (rst) begin
            seccnt <= '0;
            stage  <= '0;
            timing <= '0;
            aux    <= '0;
        end else begin
            if (acc.kind == AC_WR_SC)
                seccnt <= acc.wdata;
            else if (done)
                seccnt <= seccnt & ~(DATA_W'(1) << (DATA_W - 1));
            if (done)
                stage <= timing;
            else if (tim_wr)
                stage <= acc.wdata[TW-1:0];
            if (commit)
                timing <= stage;
            if (aux_wr)
                aux <= acc.wdata[AUX_W-1:0];
        end
    end

    always_comb begin
        claim = sc_rd | tim_rd | aux_rd;
        rdata = '0;
        if (sc_rd)       rdata = seccnt;
        else if (tim_rd) rdata = DATA_W'(stage);
        else if (aux_rd) rdata = DATA_W'(aux);
    end

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_decode
        assign pio_mode[2*d +: 2] = field_to_mode(timing[FIELD_W*d +: FIELD_W]);
    end
endmodule

// File: rtl/tfu_wide_arm.sv
module tfu_wide_arm
    import tfu_pkg::*;
#(
    parameter int ARM_READS = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  acc_kind_e kind,
    output logic      armed
);
    localparam int CW = $clog2(ARM_READS + 1);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= '0;
            armed <= 1'b0;
        end else begin
            case (kind)
                AC_NONE: ;
                AC_RD_SC: begin
                    if (run == CW'(ARM_READS - 1)) armed <= 1'b1;
                    else                           run   <= run + 1'b1;
                end
                AC_DATA: run <= '0;
                default: begin
                    run   <= '0;
                    armed <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/tfu_unlock_snoop.sv
module tfu_unlock_snoop
    import tfu_pkg::*;
#(
    parameter int NUM_DRV   = 2,
    parameter int ARM_READS = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [3:0]                    io_addr,
    input  logic                          io_rd,
    input  logic                          io_wr,
    input  logic [7:0]                    io_wdata,
    output logic [7:0]                    io_rdata,
    output logic                          io_rd_claim,
    output logic                          cfg_open,
    output logic [NUM_DRV*3-1:0]          drv_timing,
    output logic [NUM_DRV*2-1:0]          drv_pio_mode,
    output logic [2:0]                    aux_ctrl,
    output logic                          wide_mode
);
    bus_acc_t acc;
    logic     done, commit;

    always_comb begin
        acc.wr    = io_wr;
        acc.rd    = io_rd && !io_wr;
        acc.ctl   = io_addr[3];
        acc.ofs   = io_addr[2:0];
        acc.wdata = io_wdata;
        acc.kind  = classify(io_rd, io_wr, io_addr[3], io_addr[2:0]);
    end

    tfu_seq_match u_match (
        .clk(clk), .rst(rst), .enable(!cfg_open), .kind(acc.kind),
        .wbit7(io_wdata[7]), .done(done)
    );

    tfu_lock_ctrl u_lock (
        .clk(clk), .rst(rst), .done(done), .kind(acc.kind),
        .wbit0(io_wdata[0]), .open(cfg_open), .commit(commit)
    );

    tfu_timing_bank #(.NUM_DRV(NUM_DRV)) u_bank (
        .clk(clk), .rst(rst), .acc(acc), .open(cfg_open), .done(done),
        .commit(commit), .rdata(io_rdata), .claim(io_rd_claim),
        .timing(drv_timing), .pio_mode(drv_pio_mode), .aux(aux_ctrl)
    );

    tfu_wide_arm #(.ARM_READS(ARM_READS)) u_wide (
        .clk(clk), .rst(rst), .kind(acc.kind), .armed(wide_mode)
    );
endmodule

// File: rtl/tfu_unlock_checker.sv
module tfu_unlock_checker #(
    parameter int NUM_DRV = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [3:0]           io_addr,
    input logic                 io_rd,
    input logic                 io_wr,
    input logic [7:0]           io_wdata,
    input logic [7:0]           io_rdata,
    input logic                 io_rd_claim,
    input logic                 cfg_open,
    input logic [NUM_DRV*3-1:0] drv_timing,
    input logic [NUM_DRV*2-1:0] drv_pio_mode,
    input logic [2:0]           aux_ctrl,
    input logic                 wide_mode
);
    assert_reset_locked_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cfg_open && drv_timing == '0 && !wide_mode && aux_ctrl == '0));

    assert_open_on_final_read_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(io_rd && !io_wr && io_addr == 4'h2));

    assert_locked_no_claim_R5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && io_rd && !io_wr && (io_addr == 4'h3 || io_addr == 4'h4)) |-> !io_rd_claim);

    assert_timing_only_on_commit_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(drv_timing) |-> $past(cfg_open && io_wr && io_addr == 4'h2 && io_wdata[0]));

    assert_relock_by_key_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_open) |-> $past(io_rd && !io_wr && io_addr == 4'h5));

    assert_aux_only_when_open_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(aux_ctrl) |-> $past(cfg_open && io_wr && io_addr == 4'h4));

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_mode_chk
        assert_mode_in_range_R9: assert property (@(posedge clk) disable iff (rst)
            drv_pio_mode[2*d +: 2] != 2'd3);
    end

    assert_wide_after_sc_read_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(wide_mode) |-> $past(io_rd && !io_wr && io_addr == 4'h2));

    assert_unclaimed_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !io_rd_claim |-> io_rdata == 8'h00);
endmodule

bind tfu_unlock_snoop tfu_unlock_checker #(.NUM_DRV(NUM_DRV)) chk_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rd_claim(io_rd_claim),
    .cfg_open(cfg_open), .drv_timing(drv_timing), .drv_pio_mode(drv_pio_mode),
    .aux_ctrl(aux_ctrl), .wide_mode(wide_mode)
);

// File: tb/tfu_unlock_snoop_tb_top.sv
`timescale 1ns/1ps
module tfu_unlock_snoop_tb_top;
    localparam logic [3:0] A_DATA = 4'h0, A_SC = 4'h2, A_TIM = 4'h3, A_AUX = 4'h4,
                           A_KEY = 4'h5, A_DEV = 4'h6, A_CMD = 4'h7, A_ALT = 4'hE;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] io_addr = '0;
    logic       io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       io_rd_claim, cfg_open, aux_dummy;
    logic [5:0] drv_timing;
    logic [3:0] drv_pio_mode;
    logic [2:0] aux_ctrl;
    logic       wide_mode;

    int vectors = 0, errors = 0;
    bit finished = 0;
    string phase = "R1";

    // reference state
    int m_open = 0, m_pend = 0, m_pos = 0, m_sc = 0, m_stage = 0, m_act = 0,
        m_aux = 0, m_run = 0, m_wide = 0;
    int pat[7] = '{3, 2, 1, 4, 4, 1, 1}; // 1 rd sc, 2 wr sc, 3 key, 4 alt

    always #2 clk = ~clk;

    tfu_unlock_snoop dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rd_claim(io_rd_claim),
        .cfg_open(cfg_open), .drv_timing(drv_timing), .drv_pio_mode(drv_pio_mode),
        .aux_ctrl(aux_ctrl), .wide_mode(wide_mode)
    );
    assign aux_dummy = 1'b0;

    task automatic cmp(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%0h expected=%0h", req, phase, act, exp);
        end
    endtask

    function automatic int mode_of(int f);
        if (f == 4) return 1;
        if (f == 7) return 2;
        return 0;
    endfunction

    function automatic int kind_of(bit rd, bit wr, logic [3:0] a);
        if (wr) return (a == A_SC) ? 2 : (a == A_DATA ? 5 : 6);
        if (!rd) return 0;
        if (a == A_SC) return 1;
        if (a == A_KEY) return 3;
        if (a == A_ALT) return 4;
        if (a == A_DATA) return 5;
        return 6;
    endfunction

    task automatic check_outputs();
        cmp("R2/R7 cfg_open", int'(cfg_open), m_open);
        cmp("R6 drv_timing", int'(drv_timing), m_act);
        cmp("R9 mode drive0", int'(drv_pio_mode[1:0]), mode_of(m_act & 7));
        cmp("R9 mode drive1", int'(drv_pio_mode[3:2]), mode_of((m_act >> 3) & 7));
        cmp("R8 aux_ctrl", int'(aux_ctrl), m_aux);
        cmp("R10 wide_mode", int'(wide_mode), m_wide);
    endtask

    task automatic acc(bit rd, bit wr, logic [3:0] a, logic [7:0] d);
        int k, exp_rd, exp_claim, old_open;
        @(negedge clk);
        check_outputs();
        io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
        #1;
        exp_rd = 0; exp_claim = 0;
        if (rd && !wr) begin
            if (a == A_SC) begin exp_rd = m_sc; exp_claim = 1; end
            else if (m_open == 1 && a == A_TIM) begin exp_rd = m_stage; exp_claim = 1; end
            else if (m_open == 1 && a == A_AUX) begin exp_rd = m_aux; exp_claim = 1; end
        end
        cmp("R11 claim", int'(io_rd_claim), exp_claim);
        cmp((a == A_SC) ? "R3 rdata" : "R5 rdata", int'(io_rdata), exp_rd);
        // advance reference
        k = kind_of(rd, wr, a);
        old_open = m_open;
        if (old_open == 0 && k != 0) begin
            if (k == pat[m_pos] && (m_pos != 1 || d[7])) begin
                if (m_pos == 6) begin
                    m_pos = 0; m_open = 1; m_pend = 0; m_stage = m_act;
                    m_sc = m_sc & 8'h7F;
                end else m_pos++;
            end else m_pos = (k == 3) ? 1 : 0;
        end
        if (old_open == 1) begin
            if (k == 2 && d[0]) begin m_act = m_stage; m_pend = 1; end
            else if (k == 3 && m_pend == 1) begin m_open = 0; m_pend = 0; end
            if (wr && a == A_TIM) m_stage = d & 8'h3F;
            if (wr && a == A_AUX) m_aux = d & 8'h07;
        end
        if (k == 2) m_sc = d;
        if (k == 1) begin
            if (m_run == 2) m_wide = 1; else m_run++;
        end else if (k == 5) m_run = 0;
        else if (k != 0) begin m_run = 0; m_wide = 0; end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) acc(0, 0, A_DATA, 8'h00);
    endtask

    task automatic unlock_seq(logic [7:0] scv);
        acc(1, 0, A_KEY, 0); acc(0, 1, A_SC, scv | 8'h80); acc(1, 0, A_SC, 0);
        acc(1, 0, A_ALT, 0); idle(1); acc(1, 0, A_ALT, 0);
        acc(1, 0, A_SC, 0); acc(1, 0, A_SC, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        phase = "R1 reset state";
        idle(2);
        acc(1, 0, A_SC, 0);

        phase = "R3 incomplete pattern, R4 break by command write";
        acc(1, 0, A_KEY, 0); acc(0, 1, A_SC, 8'h85); acc(1, 0, A_SC, 0);
        acc(1, 0, A_ALT, 0); acc(0, 1, A_CMD, 8'h20);
        acc(1, 0, A_ALT, 0); acc(1, 0, A_SC, 0); acc(1, 0, A_SC, 0);
        acc(1, 0, A_SC, 0);

        phase = "R2 write without bit 7 does not advance";
        acc(1, 0, A_KEY, 0); acc(0, 1, A_SC, 8'h05); acc(1, 0, A_SC, 0);
        acc(1, 0, A_ALT, 0); acc(1, 0, A_ALT, 0); acc(1, 0, A_SC, 0); acc(1, 0, A_SC, 0);

        phase = "R4 key read restarts a broken retry";
        acc(1, 0, A_KEY, 0); acc(0, 1, A_SC, 8'h80); acc(1, 0, A_KEY, 0);
        acc(0, 1, A_SC, 8'h80); acc(1, 0, A_SC, 0); acc(1, 0, A_ALT, 0);
        acc(1, 0, A_ALT, 0); acc(1, 0, A_SC, 0); acc(1, 0, A_SC, 0);
        phase = "R3 bit 7 cleared after unlock";
        acc(1, 0, A_SC, 0);

        phase = "R5 staging read/write";
        acc(1, 0, A_TIM, 0); acc(0, 1, A_TIM, 8'hFC); acc(1, 0, A_TIM, 0);
        phase = "R7 key without commit stays open";
        acc(1, 0, A_KEY, 0); idle(1);
        phase = "R8 aux field";
        acc(0, 1, A_AUX, 8'hFD); acc(1, 0, A_AUX, 0);
        phase = "R6 commit";
        acc(0, 1, A_SC, 8'h01); idle(1);
        phase = "R7 relock";
        acc(1, 0, A_KEY, 0); idle(1);
        phase = "R5 locked offsets 3/4 ignored";
        acc(0, 1, A_TIM, 8'h00); acc(1, 0, A_TIM, 0);
        acc(0, 1, A_AUX, 8'h02); acc(1, 0, A_AUX, 0); idle(1);

        phase = "R5 reload and R9 other codes";
        unlock_seq(8'h00);
        acc(1, 0, A_TIM, 0);
        acc(0, 1, A_TIM, 8'h0A); acc(0, 1, A_SC, 8'h01); idle(1);
        acc(0, 1, A_TIM, 8'h20); acc(0, 1, A_SC, 8'h01);
        acc(1, 0, A_KEY, 0); idle(1);

        phase = "R10 wide mode arming";
        acc(1, 0, A_SC, 0); idle(1); acc(1, 0, A_SC, 0); acc(1, 0, A_SC, 0);
        acc(1, 0, A_DATA, 0); acc(0, 1, A_DATA, 8'h11); acc(1, 0, A_SC, 0);
        acc(0, 1, A_DEV, 8'hA0);
        acc(1, 0, A_SC, 0); acc(1, 0, A_SC, 0); acc(1, 0, A_DATA, 0);
        acc(1, 0, A_SC, 0); idle(1);
        acc(1, 0, A_SC, 0); acc(1, 0, A_SC, 0); acc(1, 0, A_ALT, 0); acc(1, 0, A_SC, 0);
        idle(2);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired in %s", phase);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule